// File: doc/BRIEF.md
# Interleaved Memory Window Request Router

This block accepts host memory reads and writes aimed at one fixed memory window and steers each one to one of up to eight downstream host-bridge ports. The incoming offset is relative to the window. The router adds the configured window base to it to form the host physical address. It then picks a port by dividing that address by the interleave granule and taking the remainder modulo the configured target count. The chosen port's decode stage answers with data or with a lookup-miss indication, and the router turns that answer into a single response pulse back to the host.

Configuration is static while requests are in flight. It consists of the window base, the window size, the target count and a granule encoding. The size must be a whole multiple of 256 MiB. A granule encoding `g` selects a granule of `256 << g` bytes. When no encoding is supplied, the 256-byte granule applies. An illegal configuration raises a flag, and every access then resolves as a miss without touching the downstream side. A failed read and a failed write get different answers: the read returns zero data with an error, and the write is dropped quietly with an OK status.

Only one request is in service at a time, so the request side sees backpressure until the response has been produced.

Top module: `memWindowRouter`

## Requirements
- R1: The downstream address `dnAddr` equals `cfgBase + reqOffset` modulo 2^ADDR_W. Unaligned offsets are forwarded unchanged.
- R2: The downstream port `dnPort` equals `(dnAddr >> (8 + g)) % cfgTargets`, where `g` is the effective granule encoding.
- R3: When `cfgGranPresent` is 0, the effective encoding is 0 (a 256-byte granule) whatever `cfgGran` holds.
- R4: `cfgError` is 1 when `cfgSize[27:0]` is non-zero, when `cfgGranPresent` is 1 with `cfgGran` above 6, or when `cfgTargets` is above 8. While it is 1, every accepted request is answered as a miss and `dnValid` stays 0.
- R5: A `cfgTargets` value of 0 does not raise `cfgError`, but every access is answered as a miss and no downstream request is issued.
- R6: A read that misses, whether from a downstream miss or from a bypass, responds with `rspError`=1 and `rspData`=0.
- R7: A write that misses responds with `rspError`=0.
- R8: A read that hits returns the downstream data unchanged with `rspError`=0. The downstream request carries the request's write flag, write data and byte size.
- R9: Byte sizes 1 to 8 are forwarded. A `reqSize` of 0 or above 8 is answered as a miss without a downstream request.
- R10: After reset, `reqReady` is 1 and `dnValid` and `rspValid` are 0. `reqReady` is 0 from the cycle after a request is accepted until the cycle after the response. `rspValid` is a single-cycle pulse, given once per request.
- R11: While `dnValid` is 1 and `dnReady` is 0, `dnValid`, `dnAddr` and `dnPort` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | ADDR_W | Window base host address |
| cfgSize | input | ADDR_W | Window size in bytes |
| cfgTargets | input | CNT_W | Number of interleave targets (0 disables) |
| cfgGran | input | GRAN_W | Granule encoding, granule = 256 << value |
| cfgGranPresent | input | 1 | 1 when cfgGran is supplied |
| cfgError | output | 1 | Configuration is illegal |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Router can accept a request |
| reqOffset | input | ADDR_W | Window-relative byte offset |
| reqSize | input | SIZE_W | Access size in bytes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | DATA_W | Little-endian write data |
| dnValid | output | 1 | Downstream request valid |
| dnReady | input | 1 | Downstream request accepted |
| dnPort | output | TGT_W | Selected target port |
| dnAddr | output | ADDR_W | Host physical address |
| dnSize | output | SIZE_W | Access size in bytes |
| dnWrite | output | 1 | Write flag |
| dnWdata | output | DATA_W | Write data |
| dnRespValid | input | 1 | Downstream answer valid |
| dnRespMiss | input | 1 | Downstream lookup missed |
| dnRespData | input | DATA_W | Downstream read data |
| rspValid | output | 1 | Response pulse |
| rspError | output | 1 | Response carries an error (poison) |
| rspData | output | DATA_W | Read data |

## Verification
A wrong port selection shows on `dnPort` in the cycle after acceptance, so the sweep over every target count from 1 to 8 and every granule encoding compares the port against the arithmetic result before the downstream handshake takes place. A stale miss flag or data register surfaces two cycles later as a wrong `rspError` or `rspData` on the response pulse. Running hits and misses back to back exposes any state that fails to clear between requests. A sequencing fault appears either as `reqReady` rising before the response or as a missing or doubled `rspValid` pulse.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } mwrState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;  // latch request fields and selected port
    logic forceMiss;   // with captureReq: resolve as miss without downstream
    logic captureRsp;  // latch downstream answer
  } mwrStrobe_t;
endpackage

// File: rtl/mwrCfgCheck.sv
module mwrCfgCheck #(
  parameter int ADDR_W      = 48,
  parameter int CNT_W       = 4,
  parameter int GRAN_W      = 3,
  parameter int MAX_TARGETS = 8,
  parameter int MAX_GRAN    = 6,
  parameter int ALIGN_BITS  = 28
) (
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [CNT_W-1:0]  cfgTargets,
  input  logic [GRAN_W-1:0] cfgGran,
  input  logic              cfgGranPresent,
  output logic              cfgError,
  output logic              windowOff,
  output logic [GRAN_W-1:0] granEff
);
  logic sizeBad;
  logic granBad;
  logic countBad;

  always_comb begin
    sizeBad   = |cfgSize[ALIGN_BITS-1:0];
    granBad   = cfgGranPresent && (int'(cfgGran) > MAX_GRAN);
    countBad  = int'(cfgTargets) > MAX_TARGETS;
    cfgError  = sizeBad | granBad | countBad;
    windowOff = (cfgTargets == '0);
    granEff   = cfgGranPresent ? cfgGran : '0;
  end
endmodule

// File: rtl/mwrCtrl.sv
module mwrCtrl
  import mwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBypass,
  input  logic       dnReady,
  input  logic       dnRespValid,
  output logic       reqReady,
  output logic       dnValid,
  output logic       rspValid,
  output mwrStrobe_t strobe
);
  mwrState_e stateQ;
  mwrState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    reqReady  = 1'b0;
    dnValid   = 1'b0;
    rspValid  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          strobe.forceMiss  = reqBypass;
          stateNext         = reqBypass ? ST_RESP : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        dnValid = 1'b1;
        if (dnReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (dnRespValid) begin
          strobe.captureRsp = 1'b1;
          stateNext         = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/mwrPath.sv
module mwrPath
  import mwr_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int DATA_W    = 64,
  parameter int SIZE_W    = 4,
  parameter int TGT_W     = 3,
  parameter int CNT_W     = 4,
  parameter int GRAN_W    = 3,
  parameter int MAX_BYTES = 8,
  parameter int GRAN_BASE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwrStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgTargets,
  input  logic [GRAN_W-1:0] granEff,
  input  logic              cfgBlock,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              dnRespMiss,
  input  logic [DATA_W-1:0] dnRespData,
  output logic              reqBypass,
  output logic [TGT_W-1:0]  dnPort,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [SIZE_W-1:0] dnSize,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);
  logic [ADDR_W-1:0] hpaNext;
  logic [ADDR_W-1:0] granIdx;
  logic [ADDR_W-1:0] divisor;
  logic [ADDR_W-1:0] modRes;
  logic              sizeBad;

  logic [ADDR_W-1:0] hpaQ;
  logic [TGT_W-1:0]  portQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic              missQ;
  logic [DATA_W-1:0] dataQ;

  always_comb begin
    hpaNext   = cfgBase + reqOffset;
    granIdx   = hpaNext >> (GRAN_BASE + int'(granEff));
    divisor   = (cfgTargets == '0) ? ADDR_W'(1) : ADDR_W'(cfgTargets);
    modRes    = granIdx % divisor;
    sizeBad   = (reqSize == '0) || (int'(reqSize) > MAX_BYTES);
    reqBypass = cfgBlock | sizeBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hpaQ   <= '0;
      portQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      missQ  <= 1'b0;
      dataQ  <= '0;
    end else begin
      if (strobe.captureReq) begin
        hpaQ   <= hpaNext;
        portQ  <= modRes[TGT_W-1:0];
        sizeQ  <= reqSize;
        writeQ <= reqWrite;
        wdataQ <= reqWdata;
        missQ  <= strobe.forceMiss;
        dataQ  <= '0;
      end
      if (strobe.captureRsp) begin
        missQ <= dnRespMiss;
        dataQ <= dnRespData;
      end
    end
  end

  always_comb begin
    dnPort   = portQ;
    dnAddr   = hpaQ;
    dnSize   = sizeQ;
    dnWrite  = writeQ;
    dnWdata  = wdataQ;
    rspError = missQ & ~writeQ;
    rspData  = (missQ | writeQ) ? '0 : dataQ;
  end
endmodule

// File: rtl/memWindowRouter.sv
module memWindowRouter
  import mwr_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int DATA_W      = 64,
  parameter int MAX_TARGETS = 8,
  parameter int MAX_GRAN    = 6,
  parameter int MAX_BYTES   = 8,
  parameter int ALIGN_BITS  = 28,
  parameter int GRAN_BASE   = 8,
  localparam int TGT_W      = $clog2(MAX_TARGETS),
  localparam int CNT_W      = $clog2(MAX_TARGETS + 1),
  localparam int GRAN_W     = $clog2(MAX_GRAN + 2),
  localparam int SIZE_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [CNT_W-1:0]  cfgTargets,
  input  logic [GRAN_W-1:0] cfgGran,
  input  logic              cfgGranPresent,
  output logic              cfgError,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [TGT_W-1:0]  dnPort,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [SIZE_W-1:0] dnSize,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  input  logic              dnRespValid,
  input  logic              dnRespMiss,
  input  logic [DATA_W-1:0] dnRespData,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);
  mwrStrobe_t        strobe;
  logic              windowOff;
  logic [GRAN_W-1:0] granEff;
  logic              reqBypass;

  mwrCfgCheck #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRAN_W(GRAN_W),
    .MAX_TARGETS(MAX_TARGETS), .MAX_GRAN(MAX_GRAN), .ALIGN_BITS(ALIGN_BITS)
  ) u_cfg (
    .cfgSize(cfgSize), .cfgTargets(cfgTargets), .cfgGran(cfgGran),
    .cfgGranPresent(cfgGranPresent), .cfgError(cfgError),
    .windowOff(windowOff), .granEff(granEff)
  );

  mwrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBypass(reqBypass),
    .dnReady(dnReady), .dnRespValid(dnRespValid), .reqReady(reqReady),
    .dnValid(dnValid), .rspValid(rspValid), .strobe(strobe)
  );

  mwrPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .TGT_W(TGT_W),
    .CNT_W(CNT_W), .GRAN_W(GRAN_W), .MAX_BYTES(MAX_BYTES), .GRAN_BASE(GRAN_BASE)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase),
    .cfgTargets(cfgTargets), .granEff(granEff), .cfgBlock(cfgError | windowOff),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .dnRespMiss(dnRespMiss), .dnRespData(dnRespData),
    .reqBypass(reqBypass), .dnPort(dnPort), .dnAddr(dnAddr), .dnSize(dnSize),
    .dnWrite(dnWrite), .dnWdata(dnWdata), .rspError(rspError), .rspData(rspData)
  );
endmodule

// File: rtl/mwrChecker.sv
module mwrChecker #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int TGT_W  = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cfgError,
  input logic [CNT_W-1:0]  cfgTargets,
  input logic              dnValid,
  input logic              dnReady,
  input logic [TGT_W-1:0]  dnPort,
  input logic [ADDR_W-1:0] dnAddr,
  input logic              rspValid,
  input logic              rspError,
  input logic [DATA_W-1:0] rspData
);
  p_dn_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnAddr) && $stable(dnPort)));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_poison_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspData == '0));

  p_port_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> (CNT_W'(dnPort) < cfgTargets));

  p_cfg_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgError && reqValid && reqReady) |=> (!dnValid && rspValid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!dnValid && !rspValid));
endmodule

bind memWindowRouter mwrChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_W(TGT_W), .CNT_W(CNT_W)
) u_mwrChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cfgError(cfgError), .cfgTargets(cfgTargets), .dnValid(dnValid),
  .dnReady(dnReady), .dnPort(dnPort), .dnAddr(dnAddr), .rspValid(rspValid),
  .rspError(rspError), .rspData(rspData)
);

// File: tb/tb_memWindowRouter.sv
`timescale 1ns/1ps
module tb_memWindowRouter;
  localparam int ADDR_W = 48;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] cfgBase = 48'h0040_0000_0000;
  logic [ADDR_W-1:0] cfgSize = 48'h0000_4000_0000;
  logic [3:0]        cfgTargets = 4'd4;
  logic [2:0]        cfgGran = 3'd0;
  logic              cfgGranPresent = 1'b1;
  logic              cfgError;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqOffset = '0;
  logic [3:0]        reqSize = 4'd8;
  logic              reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              dnValid;
  logic              dnReady = 1'b0;
  logic [2:0]        dnPort;
  logic [ADDR_W-1:0] dnAddr;
  logic [3:0]        dnSize;
  logic              dnWrite;
  logic [DATA_W-1:0] dnWdata;
  logic              dnRespValid = 1'b0;
  logic              dnRespMiss = 1'b0;
  logic [DATA_W-1:0] dnRespData = '0;
  logic              rspValid;
  logic              rspError;
  logic [DATA_W-1:0] rspData;

  memWindowRouter dut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgTargets(cfgTargets), .cfgGran(cfgGran), .cfgGranPresent(cfgGranPresent),
    .cfgError(cfgError), .reqValid(reqValid), .reqReady(reqReady),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .dnValid(dnValid), .dnReady(dnReady), .dnPort(dnPort),
    .dnAddr(dnAddr), .dnSize(dnSize), .dnWrite(dnWrite), .dnWdata(dnWdata),
    .dnRespValid(dnRespValid), .dnRespMiss(dnRespMiss), .dnRespData(dnRespData),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // observations of one access
  bit                gotRsp, sawDn, busyBad, stableBad;
  logic [2:0]        obsPort;
  logic [ADDR_W-1:0] obsAddr;
  logic [3:0]        obsSize;
  logic              obsWr;
  logic [DATA_W-1:0] obsWd;
  logic              obsErr;
  logic [DATA_W-1:0] obsData;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] off, input logic [3:0] sz,
                        input logic wr, input logic [DATA_W-1:0] wd,
                        input logic missIn, input logic [DATA_W-1:0] rd,
                        input int stall);
    int stallLeft = stall;
    bit pend = 1'b0;
    gotRsp = 0; sawDn = 0; busyBad = 0; stableBad = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOffset = off; reqSize = sz; reqWrite = wr; reqWdata = wd;
    for (int c = 0; c < 30 && !gotRsp; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      dnRespValid = 1'b0;
      if (reqReady) busyBad = 1;
      if (rspValid) begin
        gotRsp = 1; obsErr = rspError; obsData = rspData;
      end else if (dnValid) begin
        if (!sawDn) begin
          obsPort = dnPort; obsAddr = dnAddr; obsSize = dnSize;
          obsWr = dnWrite; obsWd = dnWdata;
        end else if (dnAddr != obsAddr || dnPort != obsPort) stableBad = 1;
        sawDn = 1;
        if (stallLeft > 0) begin dnReady = 1'b0; stallLeft--; end
        else begin dnReady = 1'b1; pend = 1'b1; end
      end else if (pend) begin
        dnReady = 1'b0;
        dnRespValid = 1'b1; dnRespMiss = missIn; dnRespData = rd;
        pend = 1'b0;
      end
    end
    chk(gotRsp, "R10", "response pulse seen", 64'(gotRsp), 64'd1);
    chk(!busyBad, "R10", "reqReady low while busy", 64'(busyBad), 64'd0);
    @(negedge clk);
    chk(!rspValid && reqReady, "R10", "single pulse then ready",
        64'({rspValid, reqReady}), 64'b01);
  endtask

  function automatic logic [2:0] expPort(input logic [ADDR_W-1:0] hpa, input int g, input int n);
    logic [ADDR_W-1:0] q = hpa >> (8 + g);
    return 3'(q % ADDR_W'(n));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10", "reset reqReady", 64'(reqReady), 64'd1);
    chk(!dnValid && !rspValid, "R10", "reset dnValid/rspValid",
        64'({dnValid, rspValid}), 64'd0);
    chk(cfgError == 1'b0, "R4", "legal config no error", 64'(cfgError), 64'd0);

    // Sweep of target counts and granule encodings: R1 R2 R8 R9
    for (int n = 1; n <= 8; n++) begin
      for (int g = 0; g <= 6; g++) begin
        cfgTargets = 4'(n); cfgGran = 3'(g); cfgGranPresent = 1'b1;
        for (int k = 0; k < 3; k++) begin
          logic [ADDR_W-1:0] off = ADDR_W'(k * 48'h3_1357 + n * 48'h2_0301 + g * 48'hA5 + k);
          logic [ADDR_W-1:0] hpa = cfgBase + off;
          logic [DATA_W-1:0] rd = 64'hC0DE_0000_0000_0000 ^ 64'(off);
          logic wr = k[0];
          logic [3:0] sz = 4'(1 + ((n + g + k) % 8));
          access(off, sz, wr, ~rd, 1'b0, rd, 0);
          chk(sawDn, "R9", "legal size forwarded", 64'(sawDn), 64'd1);
          chk(obsAddr == hpa, "R1", "host address", 64'(obsAddr), 64'(hpa));
          chk(obsPort == expPort(hpa, g, n), "R2", "interleave port",
              64'(obsPort), 64'(expPort(hpa, g, n)));
          chk(obsSize == sz && obsWr == wr, "R8", "size and write flag",
              64'({obsSize, obsWr}), 64'({sz, wr}));
          if (wr) begin
            chk(obsWd == ~rd, "R8", "write data", obsWd, ~rd);
            chk(obsErr == 1'b0, "R8", "write hit ok", 64'(obsErr), 64'd0);
          end else begin
            chk(obsErr == 1'b0 && obsData == rd, "R8", "read hit data", obsData, rd);
          end
        end
      end
    end

    // R3: granule absent uses 256 bytes
    cfgTargets = 4'd5; cfgGran = 3'd5; cfgGranPresent = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [ADDR_W-1:0] off = ADDR_W'(k * 48'h1_0100 + 48'h300);
      logic [ADDR_W-1:0] hpa = cfgBase + off;
      access(off, 4'd4, 1'b0, '0, 1'b0, 64'h1234, 0);
      chk(obsPort == expPort(hpa, 0, 5), "R3", "default granule port",
          64'(obsPort), 64'(expPort(hpa, 0, 5)));
    end
    cfgGran = 3'd7;
    access(48'h0, 4'd2, 1'b0, '0, 1'b0, 64'h55, 0);
    chk(cfgError == 1'b0 && sawDn, "R3", "absent encoding 7 ignored",
        64'({cfgError, sawDn}), 64'b01);
    cfgGranPresent = 1'b1; cfgGran = 3'd1;

    // R6 R7: downstream miss
    access(48'h800, 4'd8, 1'b0, '0, 1'b1, 64'hDEAD_BEEF, 0);
    chk(sawDn && obsErr && obsData == 0, "R6", "read miss poison",
        64'({obsErr, obsData[3:0]}), 64'h10);
    access(48'h900, 4'd8, 1'b1, 64'hAB, 1'b1, 64'hDEAD_BEEF, 0);
    chk(sawDn && obsErr == 1'b0, "R7", "write miss ok", 64'(obsErr), 64'd0);
    access(48'h940, 4'd8, 1'b0, '0, 1'b0, 64'h77, 0);
    chk(obsErr == 1'b0 && obsData == 64'h77, "R6", "hit after miss clears",
        obsData, 64'h77);

    // R11: stalled downstream handshake
    access(48'h1_2345, 4'd3, 1'b0, '0, 1'b0, 64'h99, 3);
    chk(!stableBad, "R11", "request held during stall", 64'(stableBad), 64'd0);
    chk(obsData == 64'h99, "R11", "stalled read data", obsData, 64'h99);

    // R9: illegal sizes bypass
    access(48'h10, 4'd0, 1'b0, '0, 1'b0, 64'h1, 0);
    chk(!sawDn && obsErr && obsData == 0, "R9", "size 0 miss",
        64'({sawDn, obsErr}), 64'b01);
    access(48'h10, 4'd9, 1'b1, 64'h5, 1'b0, 64'h1, 0);
    chk(!sawDn && !obsErr, "R9", "size 9 write dropped ok",
        64'({sawDn, obsErr}), 64'b00);

    // R5: zero targets disables window
    cfgTargets = 4'd0;
    @(negedge clk);
    chk(cfgError == 1'b0, "R5", "zero targets not config error", 64'(cfgError), 64'd0);
    access(48'h20, 4'd4, 1'b0, '0, 1'b0, 64'h1, 0);
    chk(!sawDn && obsErr && obsData == 0, "R5", "disabled read miss",
        64'({sawDn, obsErr}), 64'b01);
    access(48'h20, 4'd4, 1'b1, 64'h3, 1'b0, 64'h1, 0);
    chk(!sawDn && !obsErr, "R5", "disabled write ok", 64'({sawDn, obsErr}), 64'b00);
    cfgTargets = 4'd4;

    // R4: configuration errors
    cfgSize = 48'h0000_1000_0100;
    @(negedge clk);
    chk(cfgError == 1'b1, "R4", "size not multiple", 64'(cfgError), 64'd1);
    access(48'h0, 4'd8, 1'b0, '0, 1'b0, 64'h1, 0);
    chk(!sawDn && obsErr, "R4", "bad size read miss", 64'({sawDn, obsErr}), 64'b01);
    cfgSize = 48'h0000_3000_0000; cfgGran = 3'd7;
    @(negedge clk);
    chk(cfgError == 1'b1, "R4", "granule 7 present", 64'(cfgError), 64'd1);
    access(48'h0, 4'd8, 1'b1, 64'h2, 1'b0, 64'h1, 0);
    chk(!sawDn && !obsErr, "R4", "bad granule write dropped", 64'({sawDn, obsErr}), 64'b00);
    cfgGran = 3'd6; cfgTargets = 4'd9;
    @(negedge clk);
    chk(cfgError == 1'b1, "R4", "nine targets", 64'(cfgError), 64'd1);
    access(48'h0, 4'd8, 1'b0, '0, 1'b0, 64'h1, 0);
    chk(!sawDn && obsErr, "R4", "nine targets read miss", 64'({sawDn, obsErr}), 64'b01);
    cfgTargets = 4'd8;
    @(negedge clk);
    chk(cfgError == 1'b0, "R4", "legal config restored", 64'(cfgError), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule